// File: doc/BRIEF.md
# Dual-Input Page Program Receiver

This block is the device-side serial front end of a flash memory that accepts the dual-input page program command. It oversamples a chip-select framed serial transaction on its system clock. The 8-bit command and the 24-bit address come in one bit per serial clock on data line 0. After that, the data bytes come in two bits per serial clock on data lines 0 and 1. Each data byte goes into a page-sized staging buffer at an offset that starts at the low address byte and wraps inside the page. When chip select returns high, the block decides whether the staged page may be committed to the array.

A commit needs four things: the write-enable latch was set when the command was decoded, at least one whole data byte arrived, chip select rose exactly on a byte boundary, and the page is not protected. A commit raises a single-cycle program request together with a write-enable-latch clear. The request carries the page number, one enable per page byte and the full page image. The array write timing, erase handling and status reporting live in neighbouring blocks. The protection lookup is also done outside: this block presents the received page number and reads back a locked flag.

Top module: `dpp_receiver`

## Requirements
- R1: The first 8 rising serial clocks after chip select falls shift the command in MSB first from data line 0. Only the code 0xA2 leads to a program; any other code produces no request.
- R2: Serial clocks 8 to 31 shift in a 24-bit address MSB first on data line 0. Address bits 23..8 appear on `prog_page` and `chk_page`.
- R3: Each later serial clock carries two data bits, MSB pair first. Data line 1 carries byte bits 7, 5, 3, 1 and data line 0 carries bits 6, 4, 2, 0, so four clocks form one byte.
- R4: If `wel` is low at the eighth serial clock, the transaction is ignored and no request is raised.
- R5: A transaction that ends before one full data byte has arrived raises no request.
- R6: If chip select rises while a data byte is only partly received, no request is raised.
- R7: The first data byte goes to page offset A7..A0. Each later byte goes to the next offset, and offset 255 is followed by offset 0 of the same page.
- R8: When more than 256 bytes are shifted in, the staged page holds the most recent byte for every offset.
- R9: If `page_locked` is high in the cycle the chip select rise is detected, no request is raised.
- R10: The block works with the serial clock idling low (mode 0) and with it idling high (mode 3), and it samples on rising edges in both cases.
- R11: In a request, offsets that received no byte show enable 0 and data 0xFF. Written offsets show enable 1 and their byte, with offset i at `prog_data[8*i+7:8*i]`.
- R12: A valid commit raises `prog_req` and `wel_clr` together for exactly one system clock cycle, within four system clocks after chip select is seen high.
- R13: While `rst_n` is low, `prog_req` and `wel_clr` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial lines |
| rst_n | input | 1 | Synchronous active-low reset |
| sck | input | 1 | Serial clock from the host |
| ce_n | input | 1 | Active-low chip select framing one transaction |
| sio0 | input | 1 | Data line 0: command, address and even data bits |
| sio1 | input | 1 | Data line 1: odd data bits |
| wel | input | 1 | Write-enable latch state |
| page_locked | input | 1 | High when the page on `chk_page` is protected |
| chk_page | output | 16 | Page number presented for the protection lookup |
| prog_req | output | 1 | One-cycle program request |
| wel_clr | output | 1 | One-cycle request to clear the write-enable latch |
| prog_page | output | 16 | Page number of the request |
| prog_ben | output | 256 | One enable per page offset |
| prog_data | output | 2048 | Staged page image, offset i in bits 8i+7..8i |

## Verification
The checker watches four things on every cycle: the program request lasts exactly one cycle, it is never raised while the page lock was set, it always comes with at least one byte enable, and it stays quiet during reset. Bit order, the offset wrap, the keeping of the most recent bytes, the rejection of wrong commands, a missing write enable or a broken byte boundary, and the two clock idle levels can only be shown by the bench's transactions. The bench compares each captured page image against its own model of the page.

// File: rtl/dpp_pkg.sv
// Package dpp_pkg
// Holds the shared phase encoding and the fixed command code for the
// dual-input page program receiver. It assumes one command per chip-select frame.
package dpp_pkg;
    localparam logic [7:0] DPP_OPCODE = 8'hA2;

    typedef enum logic [1:0] {
        PH_CMD  = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2,
        PH_IDLE = 2'd3
    } dpp_phase_t;
endpackage

// File: rtl/dpp_line_sync.sv
// Module dpp_line_sync
// Registers the serial lines into the system clock domain. It produces
// single-cycle strobes for the rising serial clock edge and for the chip
// select edges. It assumes the system clock runs at least four times as fast as
// the serial clock, and that data is stable around each rising edge.
module dpp_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic ce_n,
    input  logic sio0,
    input  logic sio1,
    output logic sck_rise,
    output logic frame_open,
    output logic frame_close,
    output logic selected,
    output logic bit0,
    output logic bit1
);
    logic sck_a, sck_b, cs_a, cs_b, d0_a, d1_a;

    // Capture the lines and keep one delayed copy of the clock and select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_a <= 1'b0;
            sck_b <= 1'b0;
            cs_a  <= 1'b1;
            cs_b  <= 1'b1;
            d0_a  <= 1'b0;
            d1_a  <= 1'b0;
        end else begin
            sck_a <= sck;
            sck_b <= sck_a;
            cs_a  <= ce_n;
            cs_b  <= cs_a;
            d0_a  <= sio0;
            d1_a  <= sio1;
        end
    end

    // Derive the edge strobes from the captured and delayed copies.
    always_comb begin
        selected    = ~cs_a;
        sck_rise    = sck_a & ~sck_b & ~cs_a;
        frame_open  = ~cs_a & cs_b;
        frame_close = cs_a & ~cs_b;
        bit0        = d0_a;
        bit1        = d1_a;
    end
endmodule

// File: rtl/dpp_decoder.sv
// Module dpp_decoder
// Steps through the command, address and data phases of one frame. It checks
// the command and the write enable, latches the page and the start offset,
// and assembles each data byte from two bits per serial clock. It then emits
// one write per byte with a wrapping offset. It assumes frame_open resets it
// before every frame.
module dpp_decoder #(
    parameter int ADDR_W  = 24,
    parameter int OFF_W   = 8,
    parameter int CMD_W   = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    frame_open,
    input  logic                    step,
    input  logic                    bit0,
    input  logic                    bit1,
    input  logic                    wel,
    output logic                    armed,
    output logic                    any_byte,
    output logic                    aligned,
    output logic [ADDR_W-OFF_W-1:0] page,
    output logic                    wr_en,
    output logic [OFF_W-1:0]        wr_off,
    output logic [7:0]              wr_byte
);
    import dpp_pkg::*;

    localparam int CNT_W  = $clog2(ADDR_W);
    localparam int PAGE_W = ADDR_W - OFF_W;

    dpp_phase_t         phase;
    logic [CNT_W-1:0]   cnt;
    logic [CMD_W-1:0]   cmd_sh;
    logic [ADDR_W-1:0]  adr_sh;
    logic [5:0]         dat_sh;
    logic [1:0]         pair;
    logic [OFF_W-1:0]   next_off;
    logic [CMD_W-1:0]   cmd_full;
    logic [ADDR_W-1:0]  adr_full;

    // Form the full shift words including the bit arriving now.
    always_comb begin
        cmd_full = {cmd_sh[CMD_W-2:0], bit0};
        adr_full = {adr_sh[ADDR_W-2:0], bit0};
    end

    // Advance the frame phase and assemble the incoming fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            cnt      <= '0;
            cmd_sh   <= '0;
            adr_sh   <= '0;
            dat_sh   <= '0;
            pair     <= '0;
            next_off <= '0;
            page     <= '0;
            any_byte <= 1'b0;
            wr_en    <= 1'b0;
            wr_off   <= '0;
            wr_byte  <= '0;
        end else begin
            wr_en <= 1'b0;
            if (frame_open) begin
                phase    <= PH_CMD;
                cnt      <= '0;
                pair     <= '0;
                any_byte <= 1'b0;
            end else if (step) begin
                case (phase)
                    PH_CMD: begin
                        cmd_sh <= cmd_full;
                        if (cnt == CNT_W'(CMD_W - 1)) begin
                            cnt   <= '0;
                            phase <= (cmd_full == DPP_OPCODE && wel) ? PH_ADDR : PH_IDLE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    PH_ADDR: begin
                        adr_sh <= adr_full;
                        if (cnt == CNT_W'(ADDR_W - 1)) begin
                            cnt      <= '0;
                            page     <= adr_full[ADDR_W-1:OFF_W];
                            next_off <= adr_full[OFF_W-1:0];
                            phase    <= PH_DATA;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    PH_DATA: begin
                        dat_sh <= {dat_sh[3:0], bit1, bit0};
                        pair   <= pair + 1'b1;
                        if (pair == 2'd3) begin
                            wr_en    <= 1'b1;
                            wr_off   <= next_off;
                            wr_byte  <= {dat_sh, bit1, bit0};
                            next_off <= next_off + 1'b1;
                            any_byte <= 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // Report whether the frame may still commit at its close.
    always_comb begin
        armed   = (phase == PH_DATA);
        aligned = (pair == 2'd0);
    end

    logic [PAGE_W-1:0] unused_page_w;
    assign unused_page_w = '0;
endmodule

// File: rtl/dpp_page_buf.sv
// Module dpp_page_buf
// Stages one page of bytes with a written flag per offset. A later write to
// the same offset replaces the earlier one. Offsets that were never written
// read as the erased value. It assumes clear is pulsed at the start of each frame.
module dpp_page_buf #(
    parameter int PAGE_BYTES = 256,
    parameter int OFF_W      = $clog2(PAGE_BYTES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    wr_en,
    input  logic [OFF_W-1:0]        wr_off,
    input  logic [7:0]              wr_byte,
    output logic [PAGE_BYTES-1:0]   ben,
    output logic [PAGE_BYTES*8-1:0] image
);
    logic [7:0]            mem [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] vld;

    // Track which offsets hold a byte of the current frame.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            vld <= '0;
        end else if (wr_en) begin
            vld[wr_off] <= 1'b1;
        end
    end

    // Store the byte; unwritten cells are masked by the flags.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_off] <= wr_byte;
        end
    end

    assign ben = vld;

    // Present each offset as its byte or as the erased value.
    for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_cell
        assign image[i*8 +: 8] = vld[i] ? mem[i] : 8'hFF;
    end
endmodule

// File: rtl/dpp_receiver.sv
// Module dpp_receiver
// Top level of the dual-input page program receiver. It ties the line sampler,
// the phase decoder and the page buffer together. When the frame closes it
// decides on the commit and issues a one-cycle program request with a latch
// clear. It assumes the protection lookup answers within the same cycle
// from chk_page.
module dpp_receiver #(
    parameter int ADDR_W     = 24,
    parameter int PAGE_BYTES = 256,
    parameter int OFF_W      = $clog2(PAGE_BYTES),
    parameter int PAGE_W     = ADDR_W - OFF_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sck,
    input  logic                    ce_n,
    input  logic                    sio0,
    input  logic                    sio1,
    input  logic                    wel,
    input  logic                    page_locked,
    output logic [PAGE_W-1:0]       chk_page,
    output logic                    prog_req,
    output logic                    wel_clr,
    output logic [PAGE_W-1:0]       prog_page,
    output logic [PAGE_BYTES-1:0]   prog_ben,
    output logic [PAGE_BYTES*8-1:0] prog_data
);
    logic              sck_rise, frame_open, frame_close, selected, bit0, bit1;
    logic              armed, any_byte, aligned, wr_en;
    logic [OFF_W-1:0]  wr_off;
    logic [7:0]        wr_byte;
    logic [PAGE_W-1:0] page;
    logic              commit_ok;

    dpp_line_sync u_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .sck         (sck),
        .ce_n        (ce_n),
        .sio0        (sio0),
        .sio1        (sio1),
        .sck_rise    (sck_rise),
        .frame_open  (frame_open),
        .frame_close (frame_close),
        .selected    (selected),
        .bit0        (bit0),
        .bit1        (bit1)
    );

    dpp_decoder #(
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W),
        .CMD_W  (8)
    ) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_open (frame_open),
        .step       (sck_rise & selected),
        .bit0       (bit0),
        .bit1       (bit1),
        .wel        (wel),
        .armed      (armed),
        .any_byte   (any_byte),
        .aligned    (aligned),
        .page       (page),
        .wr_en      (wr_en),
        .wr_off     (wr_off),
        .wr_byte    (wr_byte)
    );

    dpp_page_buf #(
        .PAGE_BYTES (PAGE_BYTES),
        .OFF_W      (OFF_W)
    ) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (frame_open),
        .wr_en   (wr_en),
        .wr_off  (wr_off),
        .wr_byte (wr_byte),
        .ben     (prog_ben),
        .image   (prog_data)
    );

    // Combine the frame-close conditions into one commit decision.
    always_comb begin
        commit_ok = frame_close & armed & any_byte & aligned & ~page_locked;
    end

    // Issue the single-cycle request and latch clear on a valid commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prog_req <= 1'b0;
            wel_clr  <= 1'b0;
        end else begin
            prog_req <= commit_ok;
            wel_clr  <= commit_ok;
        end
    end

    assign chk_page  = page;
    assign prog_page = page;
endmodule

// File: rtl/dpp_receiver_chk.sv
// Module dpp_receiver_chk
// Checker for dpp_receiver, attached by bind. It watches the request pulse
// width, its relation to the lock flag and the byte enables, and its level
// during reset.
module dpp_receiver_chk #(
    parameter int PAGE_BYTES = 256
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  prog_req,
    input logic                  wel_clr,
    input logic                  page_locked,
    input logic [PAGE_BYTES-1:0] prog_ben
);
    // R12: the request never lasts longer than one cycle.
    p_req_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req |=> !prog_req);

    // R9: a request never follows a cycle in which the page was locked.
    p_req_unlocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req |-> !$past(page_locked));

    // R5: a request always carries at least one written byte.
    p_req_has_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req |-> (prog_ben != '0));

    // R13: reset keeps both pulses low on the following cycle.
    p_quiet_in_reset_r13: assert property (@(posedge clk)
        !rst_n |=> (!prog_req && !wel_clr));
endmodule

bind dpp_receiver dpp_receiver_chk #(.PAGE_BYTES(PAGE_BYTES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .prog_req    (prog_req),
    .wel_clr     (wel_clr),
    .page_locked (page_locked),
    .prog_ben    (prog_ben)
);

// File: tb/dpp_receiver_bench.sv
module dpp_receiver_bench;
    localparam int CLK_PERIOD = 10;
    localparam int PB = 256;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, ce_n = 1'b1, sio0 = 1'b0, sio1 = 1'b0;
    logic wel = 1'b0, page_locked = 1'b0;
    logic [15:0]     chk_page, prog_page;
    logic            prog_req, wel_clr;
    logic [PB-1:0]   prog_ben;
    logic [PB*8-1:0] prog_data;

    int checks = 0, fails = 0;
    int req_seen = 0, clr_seen = 0;
    logic [15:0]     cap_page;
    logic [PB-1:0]   cap_ben;
    logic [PB*8-1:0] cap_data;
    logic [7:0]      tx [600];
    logic [7:0]      exp_d [PB];
    logic            exp_v [PB];

    always #(CLK_PERIOD/2) clk = ~clk;

    dpp_receiver u_dpp_receiver (
        .clk(clk), .rst_n(rst_n), .sck(sck), .ce_n(ce_n), .sio0(sio0), .sio1(sio1),
        .wel(wel), .page_locked(page_locked), .chk_page(chk_page),
        .prog_req(prog_req), .wel_clr(wel_clr), .prog_page(prog_page),
        .prog_ben(prog_ben), .prog_data(prog_data)
    );

    // Capture requests away from the active edge.
    always @(negedge clk) begin
        if (prog_req) begin
            req_seen = req_seen + 1;
            cap_page = prog_page;
            cap_ben  = prog_ben;
            cap_data = prog_data;
        end
        if (wel_clr) clr_seen = clr_seen + 1;
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clk_bits(input logic b1, input logic b0);
        sck = 1'b0; sio1 = b1; sio0 = b0;
        repeat (2) @(negedge clk);
        sck = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    // Send one frame: command, address, nbytes data bytes, then extra dangling pairs.
    task automatic send(input logic [7:0] op, input logic [23:0] adr, input int nbytes,
                        input int extra, input bit mode3);
        sck = mode3;
        repeat (3) @(negedge clk);
        ce_n = 1'b0;
        repeat (2) @(negedge clk);
        for (int i = 7; i >= 0; i--) clk_bits(1'b0, op[i]);
        for (int i = 23; i >= 0; i--) clk_bits(1'b0, adr[i]);
        for (int k = 0; k < nbytes; k++)
            for (int p = 3; p >= 0; p--) clk_bits(tx[k][2*p+1], tx[k][2*p]);
        for (int e = 0; e < extra; e++) clk_bits(1'b1, 1'b0);
        if (!mode3) begin
            sck = 1'b0;
            repeat (2) @(negedge clk);
        end
        ce_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    // Run one frame and compare against the bench's own page model.
    task automatic run(input string tag, input logic [7:0] op, input logic [23:0] adr,
                       input int nbytes, input int extra, input bit mode3,
                       input bit we, input bit lock);
        int base, cbase, bad_b, bad_d;
        bit want;
        for (int k = 0; k < nbytes; k++) tx[k] = 8'($urandom);
        for (int o = 0; o < PB; o++) begin exp_v[o] = 1'b0; exp_d[o] = 8'hFF; end
        for (int k = 0; k < nbytes; k++) begin
            exp_v[(adr[7:0] + k) % PB] = 1'b1;
            exp_d[(adr[7:0] + k) % PB] = tx[k];
        end
        want = (op == 8'hA2) && we && (nbytes > 0) && (extra == 0) && !lock;
        wel = we; page_locked = lock;
        base = req_seen; cbase = clr_seen;
        send(op, adr, nbytes, extra, mode3);
        check((req_seen - base) == int'(want), {tag, " R12 request count"}, req_seen - base, want);
        check((clr_seen - cbase) == int'(want), {tag, " R12 latch clear count"}, clr_seen - cbase, want);
        if (want) begin
            bad_b = 0; bad_d = 0;
            for (int o = 0; o < PB; o++) begin
                if (cap_ben[o] !== exp_v[o]) bad_b++;
                if (cap_data[o*8 +: 8] !== exp_d[o]) bad_d++;
            end
            check(cap_page == adr[23:8], {tag, " R2 page"}, cap_page, adr[23:8]);
            check(bad_b == 0, {tag, " R7 R8 R11 enable mismatches"}, bad_b, 0);
            check(bad_d == 0, {tag, " R3 R7 R8 R11 data mismatches"}, bad_d, 0);
        end
        wel = 1'b0; page_locked = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 180000);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        check(prog_req == 1'b0 && wel_clr == 1'b0, "R13 reset outputs", {prog_req, wel_clr}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        run("basic mode0 R1",       8'hA2, 24'h123400, 4,   0, 1'b0, 1'b1, 1'b0);
        run("mode3 R10",            8'hA2, 24'h00AB10, 9,   0, 1'b1, 1'b1, 1'b0);
        run("wrong command R1",     8'h02, 24'h001000, 4,   0, 1'b0, 1'b1, 1'b0);
        run("no write enable R4",   8'hA2, 24'h001000, 4,   0, 1'b0, 1'b0, 1'b0);
        run("no data byte R5",      8'hA2, 24'h002000, 0,   0, 1'b0, 1'b1, 1'b0);
        run("partial byte only R5", 8'hA2, 24'h002000, 0,   3, 1'b1, 1'b1, 1'b0);
        run("off boundary R6",      8'hA2, 24'h003000, 5,   2, 1'b0, 1'b1, 1'b0);
        run("wrap in page R7",      8'hA2, 24'h4455F0, 40,  0, 1'b0, 1'b1, 1'b0);
        run("overrun R8",           8'hA2, 24'hFFFF10, 300, 0, 1'b1, 1'b1, 1'b0);
        run("protected R9",         8'hA2, 24'h005500, 6,   0, 1'b0, 1'b1, 1'b1);
        for (int t = 0; t < 20; t++) begin
            int sel = int'($urandom_range(0, 9));
            run("random",
                (sel == 0) ? 8'($urandom) : 8'hA2,
                24'($urandom),
                int'($urandom_range(1, 70)),
                (sel == 1) ? int'($urandom_range(1, 3)) : 0,
                1'($urandom),
                sel != 2,
                sel == 3);
        end
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule